// File: doc/BRIEF.md
# USB Host Controller Interrupt and Status Logic

This block keeps the sticky status bits, the interrupt-enable register and the run and suspend command bits of a simple USB host controller. Single-cycle event pulses from the transaction engine arrive on dedicated inputs. These are a finished transfer with its descriptor flags and lengths, a resume seen on the bus, a master or target abort on the system bus, and an internal processor fault. The block turns each event into a status bit that stays set until software clears it.

A single level-sensitive interrupt line is formed from the status bits and the enable register. Several enable bits can feed one status cause. The two fatal causes ignore the enables. A system-bus abort also stops the controller by dropping the run bit on its own. Software reaches the three registers through a plain 16-bit register port. Writes take effect on the clock edge, and read data is a combinational view of the addressed register.

Top module: `uhc_irq_status`

## Requirements
- R1: After reset the command register (address 0) and the enable register (address 2) read 0000h, the status register (address 1) reads 0020h, address 3 reads 0000h and `irq` is low.
- R2: Status bit 0 is set on a finished transfer whose descriptor asked for an interrupt on completion, or whose short-packet flag is set and whose actual length is strictly below its maximum length. An equal or larger actual length does not set it.
- R3: Status bit 1 is set on a finished transfer flagged with an error. If that transfer also asked for an interrupt on completion, bits 1 and 0 are both set in the same edge.
- R4: Status bit 2 is set on a resume pulse only while command bit 3 (suspend) is 1. A resume pulse while suspend is 0 leaves bit 2 at 0.
- R5: A master-abort or target-abort pulse sets status bit 3 and forces command bit 0 (run) to 0 on the same edge, even when a command write in that cycle sets run.
- R6: A processor-fault pulse sets status bit 4. Bits 3 and 4 raise `irq` whatever the enable register holds.
- R7: Writing status bits 4:0 with 1 clears them and writing 0 leaves them unchanged. If an event sets a bit in the same cycle as a clearing write, the bit ends up set.
- R8: The enable register keeps bit 0 (error/timeout), bit 1 (resume), bit 2 (completion) and bit 3 (short packet). Bits 15:4 read as 0.
- R9: `irq` is high exactly when bit 0 is set with enable bit 2 or 3 set, or bit 1 is set with enable bit 0, or bit 2 is set with enable bit 1, or bit 3 or bit 4 is set.
- R10: Events whose enable is 0 still set their status bit, while `irq` stays low.
- R11: Command bit 0 (run) and bit 3 (suspend) are stored and read back, and other command bits read as 0. Status bit 5 reads 1 exactly while run is 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select: 0 command, 1 status, 2 enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| xfer_done | input | 1 | Transfer finished pulse |
| xfer_ioc | input | 1 | Descriptor asks for an interrupt on completion |
| xfer_err | input | 1 | Transfer ended in error |
| xfer_spd | input | 1 | Descriptor enables short-packet detection |
| xfer_act_len | input | LEN_W | Actual transferred length |
| xfer_max_len | input | LEN_W | Maximum length in the descriptor |
| resume_in | input | 1 | Resume seen from a device |
| mabort_in | input | 1 | Bus master abort |
| tabort_in | input | 1 | Bus target abort |
| hpe_in | input | 1 | Host processor fault |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with LEN_W = 4. Random actual and maximum lengths then fall on the below, equal and above sides of the short-packet compare often enough to exercise that compare over thousands of transfers. The default address and data widths are kept, so all four register selects, including the unused one, are drawn at random. Random writes land on the status register in the same cycles as random events, which regularly brings set-versus-clear collisions and aborts coinciding with run writes within reach.

// File: rtl/uhc_irq_pkg.sv
package uhc_irq_pkg;

  // status bit positions (software decodes these)
  localparam int ST_INT   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_RES   = 2;
  localparam int ST_BUS   = 3;
  localparam int ST_HPE   = 4;
  localparam int ST_HALT  = 5;
  localparam int ST_STICKY = 5;   // number of sticky status bits

  // enable bit positions
  localparam int EN_TOCRC = 0;
  localparam int EN_RES   = 1;
  localparam int EN_IOC   = 2;
  localparam int EN_SP    = 3;
  localparam int EN_W     = 4;

  // command bit positions
  localparam int CMD_RUN  = 0;
  localparam int CMD_SUSP = 3;

  // register selects
  localparam int SEL_CMD  = 0;
  localparam int SEL_STS  = 1;
  localparam int SEL_IEN  = 2;

  // interrupt merge of sticky status and enables
  function automatic logic irq_of(logic [ST_STICKY-1:0] st, logic [EN_W-1:0] en);
    logic r;
    r = (st[ST_INT] & (en[EN_IOC] | en[EN_SP]))
      | (st[ST_ERR] & en[EN_TOCRC])
      | (st[ST_RES] & en[EN_RES])
      | st[ST_BUS]
      | st[ST_HPE];
    return r;
  endfunction

endpackage

// File: rtl/uhc_evt_qual.sv
module uhc_evt_qual
  import uhc_irq_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic                 xfer_done,
  input  logic                 xfer_ioc,
  input  logic                 xfer_err,
  input  logic                 xfer_spd,
  input  logic [LEN_W-1:0]     xfer_act_len,
  input  logic [LEN_W-1:0]     xfer_max_len,
  input  logic                 resume_in,
  input  logic                 suspend,
  input  logic                 mabort_in,
  input  logic                 tabort_in,
  input  logic                 hpe_in,
  output logic [ST_STICKY-1:0] set_vec,
  output logic                 bus_abort,
  output logic                 short_hit
);

  function automatic logic is_short(logic [LEN_W-1:0] act, logic [LEN_W-1:0] mx);
    return act < mx;
  endfunction

  always_comb begin
    short_hit        = xfer_done & xfer_spd & is_short(xfer_act_len, xfer_max_len);
    bus_abort        = mabort_in | tabort_in;
    set_vec          = '0;
    set_vec[ST_INT]  = (xfer_done & xfer_ioc) | short_hit;
    set_vec[ST_ERR]  = xfer_done & xfer_err;
    set_vec[ST_RES]  = resume_in & suspend;
    set_vec[ST_BUS]  = bus_abort;
    set_vec[ST_HPE]  = hpe_in;
  end

endmodule

// File: rtl/uhc_sticky_status.sv
module uhc_sticky_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] sts_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sts_q[i] <= 1'b0;
      else if (set_vec[i]) sts_q[i] <= 1'b1;
      else if (clr_vec[i]) sts_q[i] <= 1'b0;
    end

    // R7: set beats a simultaneous clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> sts_q[i]);
    // R7: write-one clears when no event competes
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !sts_q[i]);
  end

endmodule

// File: rtl/uhc_cmd_reg.sv
module uhc_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cmd,
  input  logic run_wd,
  input  logic susp_wd,
  input  logic bus_abort,
  output logic run_q,
  output logic susp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        run_q  <= run_wd;
        susp_q <= susp_wd;
      end
      if (bus_abort) run_q <= 1'b0;
    end
  end

  // R5: an abort stops the controller on the same edge
  a_r5_abort_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |=> !run_q);

endmodule

// File: rtl/uhc_irq_status.sv
module uhc_irq_status
  import uhc_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_done,
  input  logic              xfer_ioc,
  input  logic              xfer_err,
  input  logic              xfer_spd,
  input  logic [LEN_W-1:0]  xfer_act_len,
  input  logic [LEN_W-1:0]  xfer_max_len,
  input  logic              resume_in,
  input  logic              mabort_in,
  input  logic              tabort_in,
  input  logic              hpe_in,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(SEL_CMD);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(SEL_STS);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(SEL_IEN);

  logic [ST_STICKY-1:0] set_vec, clr_vec, sts_q;
  logic [EN_W-1:0]      ien_q;
  logic                 bus_abort, short_hit;
  logic                 run_q, susp_q;
  logic                 wr_cmd, wr_sts, wr_ien;
  logic                 unused_bits;

  assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
  assign wr_sts  = reg_wr && (reg_addr == A_STS);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign clr_vec = wr_sts ? reg_wdata[ST_STICKY-1:0] : '0;
  assign unused_bits = ^reg_wdata[DATA_W-1:ST_STICKY] ^ short_hit;

  uhc_evt_qual #(.LEN_W(LEN_W)) evt_i (
    .xfer_done(xfer_done), .xfer_ioc(xfer_ioc), .xfer_err(xfer_err),
    .xfer_spd(xfer_spd), .xfer_act_len(xfer_act_len), .xfer_max_len(xfer_max_len),
    .resume_in(resume_in), .suspend(susp_q), .mabort_in(mabort_in),
    .tabort_in(tabort_in), .hpe_in(hpe_in), .set_vec(set_vec),
    .bus_abort(bus_abort), .short_hit(short_hit)
  );

  uhc_sticky_status #(.N(ST_STICKY)) sts_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .sts_q(sts_q)
  );

  uhc_cmd_reg cmd_i (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd),
    .run_wd(reg_wdata[CMD_RUN]), .susp_wd(reg_wdata[CMD_SUSP]),
    .bus_abort(bus_abort), .run_q(run_q), .susp_q(susp_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= reg_wdata[EN_W-1:0];
  end

  assign irq = irq_of(sts_q, ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD: begin
        reg_rdata[CMD_RUN]  = run_q;
        reg_rdata[CMD_SUSP] = susp_q;
      end
      A_STS: begin
        reg_rdata[ST_STICKY-1:0] = sts_q;
        reg_rdata[ST_HALT]       = ~run_q;
      end
      A_IEN:   reg_rdata[EN_W-1:0] = ien_q;
      default: reg_rdata = '0;
    endcase
  end

  // R4: resume outside suspend leaves the bit clear
  a_r4_resume_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_in && !susp_q && !sts_q[ST_RES]) |=> !sts_q[ST_RES]);
  // R6: a processor fault raises the line regardless of enables
  a_r6_fatal_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    hpe_in |=> irq);
  // R8: reserved enable bits read as zero
  a_r8_ien_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_IEN) |-> (reg_rdata[DATA_W-1:EN_W] == '0));
  // R11: halted flag mirrors the run bit
  a_r11_halted_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STS) |-> (reg_rdata[ST_HALT] == !run_q));

endmodule

// File: tb/uhc_irq_status_tb_top.sv
module uhc_irq_status_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 4;
  localparam int NRAND = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        xfer_done = 0, xfer_ioc = 0, xfer_err = 0, xfer_spd = 0;
  logic [LEN_W-1:0] act_len = '0, max_len = '0;
  logic        resume_in = 0, mabort_in = 0, tabort_in = 0, hpe_in = 0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [4:0] m_sts = '0;
  logic [3:0] m_en = '0;
  logic       m_run = 0, m_susp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uhc_irq_status #(.ADDR_W(2), .DATA_W(16), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .xfer_ioc(xfer_ioc), .xfer_err(xfer_err), .xfer_spd(xfer_spd),
    .xfer_act_len(act_len), .xfer_max_len(max_len), .resume_in(resume_in),
    .mabort_in(mabort_in), .tabort_in(tabort_in), .hpe_in(hpe_in), .irq(irq)
  );

  function automatic logic exp_irq(logic [4:0] s, logic [3:0] e);
    if (s[4] || s[3]) return 1'b1;
    if (s[2] && e[1]) return 1'b1;
    if (s[1] && e[0]) return 1'b1;
    if (s[0] && (e[2] || e[3])) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_read(logic [1:0] a);
    case (a)
      2'd0:    return {12'd0, m_susp, 2'b00, m_run};
      2'd1:    return {10'd0, ~m_run, m_sts};
      2'd2:    return {12'd0, m_en};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ev = {hpe, tab, mab, res, spd, err, ioc, done}
  task automatic step(input logic wr, input logic [1:0] a, input logic [15:0] d,
                      input logic [7:0] ev, input logic [LEN_W-1:0] al,
                      input logic [LEN_W-1:0] ml);
    logic [4:0] setv;
    logic done, shortp;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    {hpe_in, tabort_in, mabort_in, resume_in, xfer_spd, xfer_err, xfer_ioc, xfer_done} = ev;
    act_len = al; max_len = ml;
    done   = ev[0];
    shortp = done && ev[3] && (al < ml);
    setv[0] = (done && ev[1]) || shortp;
    setv[1] = done && ev[2];
    setv[2] = ev[4] && m_susp;
    setv[3] = ev[5] || ev[6];
    setv[4] = ev[7];
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      if (setv[i]) m_sts[i] = 1'b1;
      else if (wr && a == 2'd1 && d[i]) m_sts[i] = 1'b0;
    end
    if (wr && a == 2'd2) m_en = d[3:0];
    if (wr && a == 2'd0) begin m_run = d[0]; m_susp = d[3]; end
    if (setv[3]) m_run = 1'b0;
    #(CLK_PERIOD/4);
    reg_wr = 0;
    {hpe_in, tabort_in, mabort_in, resume_in, xfer_spd, xfer_err, xfer_ioc, xfer_done} = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    chk(tag, {15'd0, irq}, {15'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    #1;
    rd(2'd0, 16'h0000, "R1 command after reset");
    rd(2'd1, 16'h0020, "R1 status after reset");
    rd(2'd2, 16'h0000, "R1 enable after reset");
    rd(2'd3, 16'h0000, "R1 spare address after reset");
    chk_irq(1'b0, "R1 irq after reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R8: reserved enable bits
    step(1, 2'd2, 16'hFFFF, 8'h00, 0, 0);
    rd(2'd2, 16'h000F, "R8 enable reserved bits");
    step(1, 2'd2, 16'h0000, 8'h00, 0, 0);

    // R11: command bits and halted flag
    step(1, 2'd0, 16'hFFFF, 8'h00, 0, 0);
    rd(2'd0, 16'h0009, "R11 command readback");
    rd(2'd1, 16'h0000, "R11 halted clear while running");
    step(1, 2'd1, 16'h0020, 8'h00, 0, 0);
    rd(2'd1, 16'h0000, "R11 halted not writable");

    // R4: resume only while suspended
    step(1, 2'd0, 16'h0001, 8'h00, 0, 0);
    step(0, 2'd0, 16'h0000, 8'h10, 0, 0);
    rd(2'd1, 16'h0000, "R4 resume ignored when not suspended");
    step(1, 2'd0, 16'h0009, 8'h00, 0, 0);
    step(0, 2'd0, 16'h0000, 8'h10, 0, 0);
    rd(2'd1, 16'h0004, "R4 resume taken while suspended");
    step(1, 2'd1, 16'h001F, 8'h00, 0, 0);

    // R10: disabled completion still recorded
    step(0, 2'd0, 16'h0000, 8'h03, 0, 0);
    rd(2'd1, 16'h0001, "R10 masked completion sets status");
    chk_irq(1'b0, "R10 masked completion keeps irq low");
    step(1, 2'd2, 16'h0004, 8'h00, 0, 0);
    chk_irq(1'b1, "R9 completion enabled raises irq");

    // R7: set wins, zero write ignored, one write clears
    step(1, 2'd1, 16'h0001, 8'h03, 0, 0);
    rd(2'd1, 16'h0001, "R7 set wins over clear");
    step(1, 2'd1, 16'h0000, 8'h00, 0, 0);
    rd(2'd1, 16'h0001, "R7 zero write no effect");
    step(1, 2'd1, 16'h0001, 8'h00, 0, 0);
    rd(2'd1, 16'h0000, "R7 one write clears");
    chk_irq(1'b0, "R9 irq drops after clear");

    // R3: error with completion flag sets both bits
    step(0, 2'd0, 16'h0000, 8'h07, 0, 0);
    rd(2'd1, 16'h0003, "R3 error with ioc");
    step(1, 2'd1, 16'h0003, 8'h00, 0, 0);
    step(0, 2'd0, 16'h0000, 8'h05, 0, 0);
    rd(2'd1, 16'h0002, "R3 error alone");
    step(1, 2'd1, 16'h0003, 8'h00, 0, 0);

    // R2: short packet compare
    step(0, 2'd0, 16'h0000, 8'h09, 4'd5, 4'd5);
    rd(2'd1, 16'h0000, "R2 equal length not short");
    step(0, 2'd0, 16'h0000, 8'h09, 4'd4, 4'd5);
    rd(2'd1, 16'h0001, "R2 shorter length sets bit0");
    step(1, 2'd1, 16'h0001, 8'h00, 0, 0);
    step(0, 2'd0, 16'h0000, 8'h01, 4'd1, 4'd9);
    rd(2'd1, 16'h0000, "R2 short without flag ignored");

    // R5: abort beats run write
    step(1, 2'd0, 16'h0001, 8'h40, 0, 0);
    rd(2'd0, 16'h0000, "R5 abort clears run");
    rd(2'd1, 16'h0028, "R5 abort sets bus error and halted");
    step(1, 2'd2, 16'h0000, 8'h00, 0, 0);
    chk_irq(1'b1, "R6 bus error unmasked");
    step(1, 2'd1, 16'h0008, 8'h00, 0, 0);

    // R6: processor fault with all enables off
    step(0, 2'd0, 16'h0000, 8'h80, 0, 0);
    rd(2'd1, 16'h0030, "R6 fault sets bit4");
    chk_irq(1'b1, "R6 fault raises irq unmasked");
    step(1, 2'd1, 16'h0010, 8'h00, 0, 0);

    // constrained random
    for (int n = 0; n < NRAND; n++) begin
      logic        w;
      logic [1:0]  a;
      logic [15:0] d;
      logic [7:0]  ev;
      w = ($urandom % 4) == 0;
      a = 2'($urandom % 4);
      d = 16'($urandom);
      for (int b = 0; b < 8; b++) ev[b] = ($urandom % 6) == 0;
      if (($urandom % 3) == 0) ev[0] = 1'b1;
      step(w, a, d, ev, LEN_W'($urandom), LEN_W'($urandom));
      chk_irq(exp_irq(m_sts, m_en), "R9 random irq");
      rd(2'd1, exp_read(2'd1), "R7 random status");
      if ((n % 8) == 0) rd(2'd0, exp_read(2'd0), "R11 random command");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule